// File: doc/BRIEF.md
# Polynomial Residue Arithmetic Unit over GF(2)

This block computes on values held as residues of a polynomial residue number system over GF(2). Every channel is tied to one irreducible binary polynomial (by default of degrees 3, 4 and 5). Every channel keeps a short residue whose width equals the degree of its modulus. The moduli are parameters. Each channel is a carry-free polynomial ring, and no channel ever exchanges data with another.

The unit holds one accumulator residue vector. A load request takes a full binary polynomial from the operand word and reduces it modulo every base at once. It does this bit-serially with shift-and-XOR, one input bit per clock. An add, subtract or multiply request takes a second operand that is already in residue form, packed into the operand word with the same slot layout as the result. It combines that operand with the accumulator in every channel during one clock. The accumulator is the result port. A done pulse marks each cycle in which a new result has been written.

Top module: `prns_unit`

## Requirements
- R1: While synchronous active-high reset is applied, every residue slot of `res_vec` is cleared to zero and `done` is low in the cycle after the reset edge.
- R2: Opcode 2'b11 (load) replaces channel i with `in_word` reduced modulo the i-th base. Channel i sits at `res_vec[i*RW +: RW]`, and its modulus is field i of `MOD_POLYS` (RW+1 bits per field, field 0 lowest). With the defaults, channel 0 is x^3+x+1, channel 1 is x^4+x+1 and channel 2 is x^5+x^2+1.
- R3: A load request sampled at clock edge t makes `done` high for exactly one cycle, after edge t+IN_W, and the converted result appears in that same cycle.
- R4: Opcode 2'b00 (add) sets every channel to the bitwise XOR of its accumulator residue and its operand slot `in_word[i*RW +: RW]`.
- R5: Opcode 2'b01 (subtract) gives exactly the same result as add.
- R6: Opcode 2'b10 (multiply) sets every channel to the carry-less product of its accumulator residue and its operand slot, reduced modulo that channel's base.
- R7: Operand slot bits at or above a channel's degree have no effect, and result bits at or above a channel's degree are always zero.
- R8: A request presented while a load conversion is still in progress is ignored: it produces no `done` and does not change `res_vec`.
- R9: An add, subtract or multiply request sampled at edge t updates `res_vec` and raises `done` after that same edge. Requests on consecutive cycles are each accepted in turn.
- R10: `res_vec` changes only in cycles where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 load |
| in_word | input | IN_W | Polynomial to load, or packed residue operand |
| res_vec | output | NUM_CH*RW | Accumulator residues, channel i at [i*RW +: RW] |
| done | output | 1 | High in each cycle a new result is written |

## Verification
The hardest situation to reach is a request arriving in the middle of a bit-serial conversion. An ignored request leaves nothing at the ports except the absence of a done pulse. To test it, the stimulus issues a load and then holds the strobe high with add requests for several cycles inside the conversion window. Any extra done, or any corruption of the converted value, then shows up against the scoreboard. Back-to-back arithmetic requests with operands whose high slot bits are set exercise the chained accumulator and the masking of bits above each degree.

// File: rtl/prns_pkg.sv
package prns_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_LOAD = 2'b11
  } prns_op_e;

  // Index of the highest set bit of a modulus polynomial.
  function automatic int poly_deg(input logic [31:0] p);
    int d;
    d = 0;
    for (int i = 0; i < 32; i++) begin
      if (p[i]) d = i;
    end
    return d;
  endfunction

endpackage

// File: rtl/prns_channel.sv
module prns_channel #(
  parameter int          RW  = 5,
  parameter logic [RW:0] MOD = 6'h25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_conv,
  input  logic          conv_step,
  input  logic          conv_last,
  input  logic          conv_bit,
  input  logic          arith_en,
  input  logic          is_mul,
  input  logic [RW-1:0] operand,
  output logic [RW-1:0] res
);
  localparam int          DEG  = prns_pkg::poly_deg(32'(MOD));
  localparam logic [RW-1:0] MASK = RW'((32'd1 << DEG) - 32'd1);

  logic [RW-1:0] acc_q, part_q;
  logic [RW-1:0] step_nxt, opnd_m, arith_nxt;

  // One shift-and-XOR reduction step: bring in the next input bit.
  function automatic logic [RW-1:0] red_step(input logic [RW-1:0] r, input logic b);
    logic [RW:0] t;
    t = {r, b};
    if (t[DEG]) t = t ^ MOD;
    return t[RW-1:0];
  endfunction

  // Carry-less product, then reduction modulo MOD from the top bit down.
  function automatic logic [RW-1:0] mul_mod(input logic [RW-1:0] a, input logic [RW-1:0] b);
    logic [2*RW-1:0] p;
    logic [2*RW-1:0] m;
    p = '0;
    m = {{(RW-1){1'b0}}, MOD};
    for (int i = 0; i < RW; i++) begin
      if (b[i]) p = p ^ ({{RW{1'b0}}, a} << i);
    end
    for (int k = 2*RW-1; k >= DEG; k--) begin
      if (p[k]) p = p ^ (m << (k - DEG));
    end
    return p[RW-1:0];
  endfunction

  assign opnd_m    = operand & MASK;
  assign step_nxt  = red_step(part_q, conv_bit);
  assign arith_nxt = is_mul ? mul_mod(acc_q, opnd_m) : (acc_q ^ opnd_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      part_q <= '0;
    end else if (start_conv) begin
      part_q <= '0;
    end else if (conv_step) begin
      if (conv_last) acc_q  <= step_nxt;
      else           part_q <= step_nxt;
    end else if (arith_en) begin
      acc_q <= arith_nxt;
    end
  end

  assign res = acc_q;
endmodule

// File: rtl/prns_ctrl.sv
module prns_ctrl #(
  parameter int IN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [IN_W-1:0] in_word,
  output logic            start_conv,
  output logic            arith_en,
  output logic            is_mul,
  output logic            busy,
  output logic            conv_last,
  output logic            conv_bit,
  output logic            done
);
  import prns_pkg::*;
  localparam int CW = $clog2(IN_W);

  logic [CW-1:0]   cnt_q;
  logic [IN_W-1:0] sh_q;
  logic            busy_q, done_q;
  logic            accept;
  prns_op_e        op;

  assign op         = prns_op_e'(in_op);
  assign accept     = in_valid && !busy_q;
  assign start_conv = accept && (op == OP_LOAD);
  assign arith_en   = accept && (op != OP_LOAD);
  assign is_mul     = (op == OP_MUL);
  assign conv_last  = busy_q && (cnt_q == '0);
  assign conv_bit   = sh_q[IN_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= arith_en || conv_last;
      if (start_conv) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(IN_W - 1);
        sh_q   <= in_word;
      end else if (busy_q) begin
        sh_q  <= {sh_q[IN_W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/prns_unit.sv
module prns_unit #(
  parameter int                      NUM_CH    = 3,
  parameter int                      RW        = 5,
  parameter int                      IN_W      = 16,
  parameter logic [NUM_CH*(RW+1)-1:0] MOD_POLYS = {6'h25, 6'h13, 6'h0B}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           in_op,
  input  logic [IN_W-1:0]      in_word,
  output logic [NUM_CH*RW-1:0] res_vec,
  output logic                 done
);
  logic busy_w, start_conv_w, arith_en_w, is_mul_w, conv_last_w, conv_bit_w;

  prns_ctrl #(.IN_W(IN_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_word   (in_word),
    .start_conv(start_conv_w),
    .arith_en  (arith_en_w),
    .is_mul    (is_mul_w),
    .busy      (busy_w),
    .conv_last (conv_last_w),
    .conv_bit  (conv_bit_w),
    .done      (done)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    prns_channel #(
      .RW (RW),
      .MOD(MOD_POLYS[i*(RW+1) +: RW+1])
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .start_conv(start_conv_w),
      .conv_step (busy_w),
      .conv_last (conv_last_w),
      .conv_bit  (conv_bit_w),
      .arith_en  (arith_en_w),
      .is_mul    (is_mul_w),
      .operand   (in_word[i*RW +: RW]),
      .res       (res_vec[i*RW +: RW])
    );
  end
endmodule

// File: rtl/prns_unit_chk.sv
module prns_unit_chk #(
  parameter int                      NUM_CH    = 3,
  parameter int                      RW        = 5,
  parameter int                      IN_W      = 16,
  parameter logic [NUM_CH*(RW+1)-1:0] MOD_POLYS = {6'h25, 6'h13, 6'h0B}
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [1:0]           in_op,
  input logic [IN_W-1:0]      in_word,
  input logic [NUM_CH*RW-1:0] res_vec,
  input logic                 done,
  input logic                 busy
);
  localparam int NV = NUM_CH*RW;

  function automatic logic [NV-1:0] slot_masks();
    logic [NV-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      v[i*RW +: RW] = RW'((32'd1 << prns_pkg::poly_deg(32'(MOD_POLYS[i*(RW+1) +: RW+1]))) - 32'd1);
    end
    return v;
  endfunction

  localparam logic [NV-1:0] OPND_MASK = slot_masks();

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res_vec == '0 && !done)); // R1

  AST_CONV_DONE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R3

  AST_XOR_OPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy && (in_op == 2'b00 || in_op == 2'b01)) |=>
      (res_vec == ($past(res_vec) ^ ($past(in_word[NV-1:0]) & OPND_MASK)))); // R4 R5

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !done); // R8

  AST_ARITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy && in_op != 2'b11) |=> done); // R9

  AST_CHANGE_WITH_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(res_vec) |-> done); // R10

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (res_vec & ~OPND_MASK) == '0); // R7
endmodule

bind prns_unit prns_unit_chk #(
  .NUM_CH(NUM_CH), .RW(RW), .IN_W(IN_W), .MOD_POLYS(MOD_POLYS)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_word(in_word),
  .res_vec(res_vec), .done(done), .busy(busy_w)
);

// File: tb/tb_prns_unit.sv
module tb_prns_unit;
  localparam int NUM_CH = 3;
  localparam int RW     = 5;
  localparam int IN_W   = 16;
  localparam int NV     = NUM_CH*RW;
  localparam logic [NUM_CH*(RW+1)-1:0] MODS = {6'h25, 6'h13, 6'h0B};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [1:0]      in_op = 2'b00;
  logic [IN_W-1:0] in_word = '0;
  wire  [NV-1:0]   res_vec;
  wire             done;

  prns_unit #(.NUM_CH(NUM_CH), .RW(RW), .IN_W(IN_W), .MOD_POLYS(MODS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_word(in_word),
    .res_vec(res_vec), .done(done)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [NV-1:0] exp_v[$];
  int            exp_at[$];
  string         exp_req[$];
  logic [RW-1:0] m_acc[NUM_CH];

  function automatic int unsigned base_of(input int ch);
    return int'((MODS >> (ch*(RW+1)))) & ((1 << (RW+1)) - 1);
  endfunction

  function automatic int deg_of(input int unsigned p);
    int d = 0;
    for (int i = 31; i >= 0; i--) if (p[i] && d == 0) d = i;
    return d;
  endfunction

  // Long division remainder from the top bit downwards.
  function automatic int unsigned pmod(input int unsigned v, input int unsigned p);
    int d = deg_of(p);
    for (int k = 31; k >= d; k--) if (v[k]) v = v ^ (p << (k - d));
    return v;
  endfunction

  function automatic int unsigned pmul(input int unsigned a, input int unsigned b, input int unsigned p);
    int unsigned pr = 0;
    for (int i = 0; i < RW; i++) if (a[i]) pr = pr ^ (b << i);
    return pmod(pr, p);
  endfunction

  task automatic check(input bit ok, input string req, input logic [NV-1:0] got, input logic [NV-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // Driver: called at a negedge with the unit idle; computes the expectation.
  task automatic issue(input logic [1:0] op, input logic [IN_W-1:0] w, input string req);
    logic [NV-1:0] e;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      int unsigned p   = base_of(ch);
      int unsigned msk = (1 << deg_of(p)) - 1;
      int unsigned od  = (int'(w) >> (ch*RW)) & msk;
      if (op == 2'b11)      m_acc[ch] = RW'(pmod(int'(w), p));
      else if (op == 2'b10) m_acc[ch] = RW'(pmul(int'(m_acc[ch]), od, p));
      else                  m_acc[ch] = m_acc[ch] ^ RW'(od);
      e[ch*RW +: RW] = m_acc[ch];
    end
    exp_v.push_back(e);
    exp_at.push_back(cyc + 1 + ((op == 2'b11) ? IN_W : 0));
    exp_req.push_back(req);
    in_valid = 1'b1;
    in_op    = op;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_v.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever a result is flagged.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_v.size() == 0) begin
        check(1'b0, "R8 unexpected done", res_vec, '0);
      end else begin
        logic [NV-1:0] e;
        int at;
        string rq;
        e  = exp_v.pop_front();
        at = exp_at.pop_front();
        rq = exp_req.pop_front();
        check(res_vec == e, rq, res_vec, e);
        check(cyc == at, {rq, " timing R3/R9"}, NV'(cyc), NV'(at));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired, actual hung expected done");
    summary();
  end

  initial begin
    for (int ch = 0; ch < NUM_CH; ch++) m_acc[ch] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(res_vec == '0 && done == 1'b0, "R1 reset state", res_vec, '0);

    // R2 conversions of assorted polynomials
    issue(2'b11, 16'h0000, "R2 load zero");      wait_idle();
    issue(2'b11, 16'hFFFF, "R2 load all ones");  wait_idle();
    issue(2'b11, 16'h8001, "R2 load 8001");      wait_idle();
    issue(2'b11, 16'h1234, "R2 load 1234");      wait_idle();

    // R4 R5 R6 R9 back-to-back arithmetic
    issue(2'b00, 16'h1AC7, "R4 add");
    issue(2'b01, 16'h1AC7, "R5 sub undoes add");
    issue(2'b10, 16'h0421, "R6 mul by one");
    issue(2'b10, 16'h2D6B, "R6 mul");
    issue(2'b10, 16'h0000, "R6 mul by zero");
    wait_idle();

    // R7 operand high bits ignored
    issue(2'b11, 16'h0000, "R2 load zero again"); wait_idle();
    issue(2'b00, 16'h7FFF, "R7 add high bits masked");
    issue(2'b10, 16'h7FFF, "R7 mul high bits masked");
    wait_idle();

    // R8 requests during a conversion are ignored
    issue(2'b11, 16'hBEEF, "R8 load then ignored requests");
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1;
      in_op    = (i % 2 == 0) ? 2'b00 : 2'b11;
      in_word  = 16'h5A5A;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_idle();
    issue(2'b00, 16'h0000, "R8 result kept after ignored requests");
    wait_idle();

    // mixed random traffic, R10 covered by the scoreboard ordering
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      issue(op, 16'($urandom), "R2/R4/R5/R6 random traffic");
      if (op == 2'b11) wait_idle();
    end
    wait_idle();
    repeat (3) @(negedge clk);
    check(exp_v.size() == 0, "R10 all results delivered", NV'(exp_v.size()), '0);
    summary();
  end
endmodule